// File: doc/BRIEF.md
# Multiplexed Code-Fetch Router

This block sits between an 8-bit processor core and its program store. The core presents a 16-bit code address, and the block returns one byte. The byte comes either from a 1 KB on-chip SRAM or from external program memory, and the block decides which one serves each fetch.

External fetches use a narrow multiplexed bus with four fixed phases. One 8-bit port first carries the low address byte and later the returned data. A second port holds the high address byte for the whole fetch. An address strobe tells an outside latch when to capture the low byte. An active-low code output-enable gates the memory onto the shared port.

The SRAM window is 0400h–07FFh. When the code-RAM enable is set and the permit input is high, fetches inside that window complete in a single clock with no bus activity.

A data-side port uses a 2-bit mode to route accesses. It can map the same SRAM at 0000h–03FFh as data memory. In that case the SRAM acts as merged code and data storage: a data write is seen by code fetches, and this also holds in the same cycle.

Top module: `cfetch_unit`

## Requirements
- R1: A synchronous reset clears the code-RAM enable and the data mode to 00. It sets `addr_strobe_o` low, `code_oe_n_o` high, `lo_bus_oe` low, `req_ready` high and `rsp_valid` low.
- R2: In the first cycle after an external fetch is accepted, `addr_strobe_o` and `lo_bus_oe` are high. In that cycle `lo_bus_o` equals address bits 7:0 and `hi_addr_o` equals address bits 15:8.
- R3: In the second cycle, `addr_strobe_o` and `lo_bus_oe` are low and `code_oe_n_o` is high. In the third and fourth cycles `code_oe_n_o` is low. `hi_addr_o` stays fixed through all four cycles.
- R4: `lo_bus_i` is captured at the end of the fourth cycle. In the next cycle `rsp_valid` is high for exactly one cycle, `rsp_data` carries the captured byte, and `code_oe_n_o` is high again.
- R5: `req_ready` is low while an external fetch is in progress. A request presented in that time is ignored.
- R6: A fetch is internal when all three of these hold: the code-RAM enable is set, `code_int_permit` is high, and the address is in 0400h–07FFh. An internal fetch returns SRAM byte (address bits 9:0) with `rsp_valid` in the cycle after acceptance, and `addr_strobe_o` and `code_oe_n_o` do not move. Internal fetches may follow each other every cycle.
- R7: With the code-RAM enable set, addresses outside 0400h–07FFh go to the external bus. This includes addresses whose bits 9:0 match a window entry.
- R8: With `code_int_permit` low, every fetch goes to the external bus, whatever the code-RAM enable says.
- R9: A data access is internal when data-mode bit 0 is 1 and the address is in 0000h–03FFh. Modes 00 and the reserved 10 are always external. An internal read returns the byte with `data_rvalid` one cycle later. `data_ext_o` flags a requested access that is not internal, and such an access leaves the SRAM unchanged.
- R10: A data write to internal address A is returned by a code fetch of A+0400h. This holds for a later fetch and for a fetch in the same cycle, which returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Load the configuration fields below |
| cfg_pram_i | input | 1 | Code-RAM enable value to load |
| cfg_dmode_i | input | 2 | Data mode value to load |
| code_int_permit | input | 1 | Low forces all code fetches external |
| req_valid | input | 1 | Fetch request |
| req_addr | input | 16 | Fetch address |
| req_ready | output | 1 | Block idle, request will be taken |
| rsp_valid | output | 1 | Fetched byte valid, one-cycle pulse |
| rsp_data | output | 8 | Fetched byte |
| data_req | input | 1 | Data access request |
| data_we | input | 1 | Data access is a write |
| data_addr | input | 16 | Data address |
| data_wdata | input | 8 | Data write byte |
| data_rvalid | output | 1 | Internal data read result valid |
| data_rdata | output | 8 | Internal data read byte |
| data_ext_o | output | 1 | Current data access routed external |
| lo_bus_o | output | 8 | Shared port, driven value |
| lo_bus_oe | output | 1 | Shared port drive enable |
| lo_bus_i | input | 8 | Shared port, sampled value |
| hi_addr_o | output | 8 | High address byte |
| addr_strobe_o | output | 1 | Address-latch strobe, active high |
| code_oe_n_o | output | 1 | External code output enable, active low |

## Verification
A data write into the SRAM and an internal code fetch can land on the same entry in the same clock. This is where the merged-memory rule is most likely to break. The bench drives both ports in one cycle: the data side writes 0077h while the fetch side reads 0477h. The entry has first been seeded with a different byte, so a stale read cannot pass. The returned code byte must be the newly written one, and a later fetch of the same address must still return it.

// File: rtl/cfetch_pkg.sv
package cfetch_pkg;
  localparam int unsigned CF_AW  = 16;
  localparam int unsigned CF_DW  = 8;
  localparam int unsigned CF_RAW = 10;
  localparam int unsigned CF_MW  = 2;

  localparam logic [CF_AW-1:0] CF_CODE_BASE = 16'h0400;
  localparam logic [CF_AW-1:0] CF_DATA_BASE = 16'h0000;

  typedef enum logic [2:0] {
    XB_IDLE = 3'd0,
    XB_ADDR = 3'd1,
    XB_TURN = 3'd2,
    XB_RD1  = 3'd3,
    XB_RD2  = 3'd4
  } xb_state_t;
endpackage

// File: rtl/cfetch_route.sv
module cfetch_route #(
  parameter int unsigned AW  = 16,
  parameter int unsigned RAW = 10,
  parameter int unsigned MW  = 2,
  parameter logic [AW-1:0] CODE_BASE = 'h0400,
  parameter logic [AW-1:0] DATA_BASE = 'h0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_pram_i,
  input  logic [MW-1:0] cfg_dmode_i,
  input  logic          code_int_permit,
  input  logic [AW-1:0] code_addr,
  input  logic [AW-1:0] data_addr,
  output logic          code_int,
  output logic          data_int
);
  logic          pram_q;
  logic [MW-1:0] dmode_q;

  function automatic logic win_hit(input logic [AW-1:0] a, input logic [AW-1:0] base);
    return (a >> RAW) == (base >> RAW);
  endfunction

  function automatic logic code_goes_int(input logic [AW-1:0] a, input logic en, input logic ok);
    return ok & en & win_hit(a, CODE_BASE);
  endfunction

  function automatic logic data_goes_int(input logic [AW-1:0] a, input logic [MW-1:0] m);
    return m[0] & win_hit(a, DATA_BASE);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pram_q  <= 1'b0;
      dmode_q <= '0;
    end else if (cfg_wr) begin
      pram_q  <= cfg_pram_i;
      dmode_q <= cfg_dmode_i;
    end
  end

  assign code_int = code_goes_int(code_addr, pram_q, code_int_permit);
  assign data_int = data_goes_int(data_addr, dmode_q);
endmodule

// File: rtl/cfetch_sram.sv
module cfetch_sram #(
  parameter int unsigned RAW = 10,
  parameter int unsigned DW  = 8
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_idx,
  input  logic [DW-1:0]  wr_data,
  input  logic [RAW-1:0] ca_idx,
  output logic [DW-1:0]  ca_data,
  input  logic [RAW-1:0] db_idx,
  output logic [DW-1:0]  db_data
);
  localparam int unsigned DEPTH = 1 << RAW;

  logic [DW-1:0] mem [DEPTH];

  function automatic logic [DW-1:0] fwd(input logic we, input logic [RAW-1:0] wi,
                                        input logic [DW-1:0] wd, input logic [RAW-1:0] ri,
                                        input logic [DW-1:0] stored);
    return (we && wi == ri) ? wd : stored;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign ca_data = fwd(wr_en, wr_idx, wr_data, ca_idx, mem[ca_idx]);
  assign db_data = fwd(wr_en, wr_idx, wr_data, db_idx, mem[db_idx]);
endmodule

// File: rtl/cfetch_xbus.sv
module cfetch_xbus
  import cfetch_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  localparam int unsigned HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] lo_o,
  output logic          lo_oe,
  output logic [HW-1:0] hi_o,
  output logic          ale,
  output logic          psen_n,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_byte
);
  xb_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= XB_IDLE;
      lo_o    <= '0;
      lo_oe   <= 1'b0;
      hi_o    <= '0;
      ale     <= 1'b0;
      psen_n  <= 1'b1;
      done    <= 1'b0;
      rd_byte <= '0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        XB_IDLE: if (start) begin
          st_q  <= XB_ADDR;
          ale   <= 1'b1;
          lo_oe <= 1'b1;
          lo_o  <= addr[DW-1:0];
          hi_o  <= addr[AW-1:DW];
        end
        XB_ADDR: begin
          st_q  <= XB_TURN;
          ale   <= 1'b0;
          lo_oe <= 1'b0;
        end
        XB_TURN: begin
          st_q   <= XB_RD1;
          psen_n <= 1'b0;
        end
        XB_RD1: st_q <= XB_RD2;
        XB_RD2: begin
          st_q    <= XB_IDLE;
          psen_n  <= 1'b1;
          rd_byte <= bus_i;
          done    <= 1'b1;
        end
        default: st_q <= XB_IDLE;
      endcase
    end
  end

  assign busy = (st_q != XB_IDLE);
endmodule

// File: rtl/cfetch_unit.sv
module cfetch_unit
  import cfetch_pkg::*;
#(
  parameter int unsigned ADDR_W = CF_AW,
  parameter int unsigned DATA_W = CF_DW,
  parameter int unsigned RAM_AW = CF_RAW,
  parameter int unsigned MODE_W = CF_MW,
  localparam int unsigned HI_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_pram_i,
  input  logic [MODE_W-1:0] cfg_dmode_i,
  input  logic              code_int_permit,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              data_req,
  input  logic              data_we,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic [DATA_W-1:0] data_wdata,
  output logic              data_rvalid,
  output logic [DATA_W-1:0] data_rdata,
  output logic              data_ext_o,
  output logic [DATA_W-1:0] lo_bus_o,
  output logic              lo_bus_oe,
  input  logic [DATA_W-1:0] lo_bus_i,
  output logic [HI_W-1:0]   hi_addr_o,
  output logic              addr_strobe_o,
  output logic              code_oe_n_o
);
  // named internal events, observed by the checker
  logic xbus_busy;
  logic int_hit;
  logic fetch_accept;
  logic ext_start;

  logic              dat_int;
  logic              sram_we;
  logic [DATA_W-1:0] ca_data;
  logic [DATA_W-1:0] db_data;
  logic              xb_done;
  logic [DATA_W-1:0] xb_byte;
  logic              int_rsp_q;
  logic [DATA_W-1:0] int_byte_q;
  logic              drd_q;
  logic [DATA_W-1:0] drd_byte_q;

  cfetch_route #(
    .AW(ADDR_W), .RAW(RAM_AW), .MW(MODE_W),
    .CODE_BASE(ADDR_W'(CF_CODE_BASE)), .DATA_BASE(ADDR_W'(CF_DATA_BASE))
  ) u_route (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_pram_i(cfg_pram_i), .cfg_dmode_i(cfg_dmode_i),
    .code_int_permit(code_int_permit),
    .code_addr(req_addr), .data_addr(data_addr),
    .code_int(int_hit), .data_int(dat_int)
  );

  assign sram_we = data_req & data_we & dat_int;

  cfetch_sram #(.RAW(RAM_AW), .DW(DATA_W)) u_sram (
    .clk(clk),
    .wr_en(sram_we), .wr_idx(data_addr[RAM_AW-1:0]), .wr_data(data_wdata),
    .ca_idx(req_addr[RAM_AW-1:0]), .ca_data(ca_data),
    .db_idx(data_addr[RAM_AW-1:0]), .db_data(db_data)
  );

  assign req_ready    = ~xbus_busy;
  assign fetch_accept = req_valid & req_ready;
  assign ext_start    = fetch_accept & ~int_hit;

  cfetch_xbus #(.AW(ADDR_W), .DW(DATA_W)) u_xbus (
    .clk(clk), .rst(rst),
    .start(ext_start), .addr(req_addr), .bus_i(lo_bus_i),
    .lo_o(lo_bus_o), .lo_oe(lo_bus_oe), .hi_o(hi_addr_o),
    .ale(addr_strobe_o), .psen_n(code_oe_n_o),
    .busy(xbus_busy), .done(xb_done), .rd_byte(xb_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_rsp_q  <= 1'b0;
      int_byte_q <= '0;
      drd_q      <= 1'b0;
      drd_byte_q <= '0;
    end else begin
      int_rsp_q <= fetch_accept & int_hit;
      if (fetch_accept & int_hit) int_byte_q <= ca_data;
      drd_q <= data_req & ~data_we & dat_int;
      if (data_req & ~data_we & dat_int) drd_byte_q <= db_data;
    end
  end

  assign rsp_valid   = int_rsp_q | xb_done;
  assign rsp_data    = xb_done ? xb_byte : int_byte_q;
  assign data_rvalid = drd_q;
  assign data_rdata  = drd_byte_q;
  assign data_ext_o  = data_req & ~dat_int;
endmodule

// File: rtl/cfetch_chk.sv
module cfetch_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned HI_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              lo_bus_oe,
  input logic              addr_strobe_o,
  input logic              code_oe_n_o,
  input logic              code_int_permit,
  input logic [HI_W-1:0]   hi_addr_o,
  input logic              xbus_busy,
  input logic              int_hit,
  input logic              fetch_accept,
  input logic              ext_start
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!addr_strobe_o && code_oe_n_o && !lo_bus_oe && !rsp_valid));

  // R2
  addr_phase_chk: assert property (@(posedge clk) disable iff (rst)
    ext_start |=> (addr_strobe_o && lo_bus_oe));

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    addr_strobe_o |=> (!addr_strobe_o && !lo_bus_oe && code_oe_n_o));

  // R3
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(addr_strobe_o && !code_oe_n_o));

  // R3
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (xbus_busy && $past(xbus_busy)) |-> $stable(hi_addr_o));

  // R4
  sample_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!code_oe_n_o && $past(!code_oe_n_o)) |=> (rsp_valid && code_oe_n_o));

  // R5
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    xbus_busy |-> !req_ready);

  // R6
  internal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_accept && int_hit) |=> (rsp_valid && !addr_strobe_o && code_oe_n_o));

  // R8
  permit_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!code_int_permit && req_valid && req_ready) |=> addr_strobe_o);
endmodule

bind cfetch_unit cfetch_chk #(.ADDR_W(ADDR_W), .HI_W(HI_W)) u_cfetch_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .lo_bus_oe(lo_bus_oe), .addr_strobe_o(addr_strobe_o),
  .code_oe_n_o(code_oe_n_o), .code_int_permit(code_int_permit), .hi_addr_o(hi_addr_o),
  .xbus_busy(xbus_busy), .int_hit(int_hit), .fetch_accept(fetch_accept),
  .ext_start(ext_start)
);

// File: tb/cfetch_unit_test.sv
module cfetch_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, cfg_pram_i = 0;
  logic [1:0] cfg_dmode_i = 0;
  logic code_int_permit = 1;
  logic req_valid = 0;
  logic [15:0] req_addr = 0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic data_req = 0, data_we = 0;
  logic [15:0] data_addr = 0;
  logic [7:0] data_wdata = 0;
  logic data_rvalid, data_ext_o;
  logic [7:0] data_rdata;
  logic [7:0] lo_bus_o, lo_bus_i = 0, hi_addr_o;
  logic lo_bus_oe, addr_strobe_o, code_oe_n_o;

  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cfetch_unit uut (.*);

  typedef struct packed {
    logic        pram;
    logic        permit;
    logic [15:0] addr;
    logic [7:0]  ext_byte;
    logic        is_int;
    logic [7:0]  expect_byte;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 16'h0410, 8'hEE, 1'b1, 8'h5A},
    '{1'b1, 1'b1, 16'h07FF, 8'hEE, 1'b1, 8'h99},
    '{1'b1, 1'b1, 16'h0400, 8'hEE, 1'b1, 8'h11},
    '{1'b1, 1'b1, 16'h03FF, 8'h3C, 1'b0, 8'h3C},
    '{1'b1, 1'b1, 16'h0800, 8'h47, 1'b0, 8'h47},
    '{1'b0, 1'b1, 16'h0410, 8'h81, 1'b0, 8'h81},
    '{1'b1, 1'b0, 16'h0410, 8'h92, 1'b0, 8'h92},
    '{1'b0, 1'b0, 16'h1234, 8'hA5, 1'b0, 8'hA5},
    '{1'b1, 1'b1, 16'hFC10, 8'h6D, 1'b0, 8'h6D}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic set_cfg(input logic pr, input logic [1:0] dm);
    @(negedge clk);
    cfg_wr = 1; cfg_pram_i = pr; cfg_dmode_i = dm;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic dwrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    data_req = 1; data_we = 1; data_addr = a; data_wdata = d;
    @(negedge clk);
    data_req = 0; data_we = 0;
  endtask

  task automatic dread(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    data_req = 1; data_we = 0; data_addr = a;
    @(negedge clk);
    data_req = 0;
    check(tag, data_rvalid, 1);
    check(tag, data_rdata, exp);
  endtask

  task automatic dprobe(input logic [15:0] a, input logic exp_ext, input string tag);
    @(negedge clk);
    data_req = 1; data_we = 0; data_addr = a;
    #1 check(tag, data_ext_o, exp_ext);
    @(negedge clk);
    data_req = 0;
  endtask

  task automatic fetch(input logic [15:0] a, input logic [7:0] eb, input logic is_int,
                       input logic [7:0] exp, input string tag);
    @(negedge clk);
    check("R5", req_ready, 1);
    req_valid = 1; req_addr = a; lo_bus_i = eb;
    @(negedge clk);
    req_valid = 0;
    if (is_int) begin
      check(tag, rsp_valid, 1);
      check(tag, rsp_data, exp);
      check("R6", addr_strobe_o, 0);
      check("R6", code_oe_n_o, 1);
    end else begin
      check("R2", addr_strobe_o, 1);
      check("R2", lo_bus_oe, 1);
      check("R2", lo_bus_o, a[7:0]);
      check("R2", hi_addr_o, a[15:8]);
      check("R5", req_ready, 0);
      @(negedge clk);
      check("R3", addr_strobe_o, 0);
      check("R3", lo_bus_oe, 0);
      check("R3", code_oe_n_o, 1);
      @(negedge clk);
      check("R3", code_oe_n_o, 0);
      @(negedge clk);
      check("R3", code_oe_n_o, 0);
      check("R3", hi_addr_o, a[15:8]);
      @(negedge clk);
      check("R4", rsp_valid, 1);
      check(tag, rsp_data, exp);
      check("R4", code_oe_n_o, 1);
      @(negedge clk);
      check("R4", rsp_valid, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", addr_strobe_o, 0);
    check("R1", code_oe_n_o, 1);
    check("R1", lo_bus_oe, 0);
    check("R1", req_ready, 1);
    check("R1", rsp_valid, 0);
    rst = 0;

    // preload SRAM through the data side (mode 01)
    set_cfg(1, 2'b01);
    dwrite(16'h0010, 8'h5A);
    dwrite(16'h03FF, 8'h99);
    dwrite(16'h0000, 8'h11);

    // vector walk: R6 internal, R7 outside window, R8 permit low
    for (int i = 0; i < NV; i++) begin
      set_cfg(VECS[i].pram, 2'b01);
      code_int_permit = VECS[i].permit;
      fetch(VECS[i].addr, VECS[i].ext_byte, VECS[i].is_int, VECS[i].expect_byte,
            VECS[i].is_int ? "R6" : (!VECS[i].permit ? "R8" : "R7"));
    end
    code_int_permit = 1;

    // R6 back-to-back internal fetches
    set_cfg(1, 2'b01);
    @(negedge clk);
    req_valid = 1; req_addr = 16'h0410;
    @(negedge clk);
    check("R6", rsp_valid, 1);
    check("R6", rsp_data, 8'h5A);
    req_addr = 16'h07FF;
    @(negedge clk);
    req_valid = 0;
    check("R6", rsp_valid, 1);
    check("R6", rsp_data, 8'h99);

    // R5 requests during an external fetch are ignored
    @(negedge clk);
    req_valid = 1; req_addr = 16'h2000; lo_bus_i = 8'h17;
    @(negedge clk);
    req_addr = 16'h0410;
    @(negedge clk);
    check("R5", rsp_valid, 0);
    @(negedge clk);
    check("R5", rsp_valid, 0);
    @(negedge clk);
    req_valid = 0;
    check("R5", rsp_valid, 0);
    @(negedge clk);
    check("R5", rsp_valid, 1);
    check("R5", rsp_data, 8'h17);
    @(negedge clk);
    check("R5", rsp_valid, 0);
    check("R5", addr_strobe_o, 0);

    // R9 data routing by mode
    dwrite(16'h0055, 8'h4E);
    dread(16'h0055, 8'h4E, "R9");
    dprobe(16'h0010, 0, "R9");
    dprobe(16'h0400, 1, "R9");
    set_cfg(1, 2'b11);
    dprobe(16'h03FF, 0, "R9");
    set_cfg(1, 2'b10);
    dprobe(16'h0010, 1, "R9");
    set_cfg(1, 2'b00);
    dprobe(16'h0010, 1, "R9");
    dwrite(16'h0055, 8'hFF);
    set_cfg(1, 2'b01);
    dread(16'h0055, 8'h4E, "R9");

    // R10 merged memory, same-cycle write and fetch
    dwrite(16'h0077, 8'h10);
    @(negedge clk);
    data_req = 1; data_we = 1; data_addr = 16'h0077; data_wdata = 8'hC3;
    req_valid = 1; req_addr = 16'h0477;
    @(negedge clk);
    data_req = 0; data_we = 0; req_valid = 0;
    check("R10", rsp_valid, 1);
    check("R10", rsp_data, 8'hC3);
    fetch(16'h0477, 8'h00, 1, 8'hC3, "R10");

    // R1 reset clears the configuration
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    fetch(16'h0400, 8'h5B, 0, 8'h5B, "R1");
    dprobe(16'h0010, 1, "R1");

    finish_run();
  end
endmodule